// File: doc/BRIEF.md
# I2C EEPROM Frame Sequencer

This block is an I2C bus master that carries out complete EEPROM transactions from a single start pulse. It takes a device address, a memory sub-address and a read/write select. In write mode it sends a small buffer of data bytes to the sub-address. In read mode it sets the slave's pointer with a dummy write, issues a repeated START, and collects the same number of bytes into a read buffer. The bus lines are open-drain. The block only ever pulls SCL or SDA low through an output enable, and it reads SDA back through an input pin.

Every slave acknowledge slot is checked. When the slave leaves SDA high in that slot, the block raises an acknowledge-failure flag and closes the frame with a STOP. It then clears the flag and re-runs the whole frame from a fresh START. A retry limit bounds how often this happens. Once the limit is used up, the block goes idle and holds an error flag until the next start pulse. The SCL rate is set by a quarter-period divider input. With a 100 MHz system clock, a value of 399 gives the nominal 62.5 kHz.

The address, sub-address, write buffer and divider inputs must be held stable while the block is busy. Start pulses that arrive while busy are not acted upon.

Top module: `eeprom_seq_top`

## Requirements
- R1: After reset, busy, ackFail and errSticky are 0, both sclOe and sdaOe are 0 (lines released), and rdData is all zeros.
- R2: A one-cycle startPulse while idle makes busy read 1 on the following cycle. Busy stays 1 until the final STOP has completed. When busy returns to 0, both bus lines are released.
- R3: Each bus bit takes four quarter periods of clkDiv+1 system clocks each, so consecutive SCL rising edges are 4*(clkDiv+1) cycles apart. clkDiv must be at least 2.
- R4: SDA changes only while SCL is low. The only exceptions are a START (SDA falls while SCL is high) and a STOP (SDA rises while SCL is high). Each frame attempt therefore shows exactly one STOP.
- R5: A write frame is START, {devAddr, 0}, subAddr, then data bytes 0..NUM_BYTES-1, then STOP. Data byte k is taken from wrData[8k+7:8k]. Every byte is sent MSB first on 8 SCL pulses, followed by a ninth pulse on which the slave must pull SDA low.
- R6: A read frame is START, {devAddr, 0}, subAddr, repeated START, {devAddr, 1}, then NUM_BYTES received bytes, then STOP. Received bytes are sampled MSB first, and received byte k is stored in rdData[8k+7:8k].
- R7: While reading, the master pulls SDA low on the ninth pulse after every received byte except the last. After the last byte it leaves SDA released (not-acknowledge) and then issues STOP.
- R8: A high SDA in any slave acknowledge slot sets ackFail while busy. The frame then ends with STOP and restarts from a new START, with ackFail cleared at that restart. A successful retry ends with ackFail 0.
- R9: At most retryLimit restarts are made. When one more acknowledge failure occurs after that, busy drops and both errSticky and ackFail stay 1. With retryLimit 0, the first failure ends the transaction.
- R10: A startPulse accepted while idle clears errSticky and ackFail on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to run a transaction |
| readMode | input | 1 | 1 selects a read frame, 0 a write frame; latched at start |
| devAddr | input | 7 | 7-bit slave device address |
| subAddr | input | 8 | Memory sub-address inside the slave |
| wrData | input | NUM_BYTES*8 | Write buffer, byte k at bits 8k+7:8k |
| clkDiv | input | DIV_W | Quarter SCL period minus one, in system clocks |
| retryLimit | input | RETRY_W | Maximum number of automatic restarts |
| sdaIn | input | 1 | Level read back from the SDA line |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| rdData | output | NUM_BYTES*8 | Read buffer, byte k at bits 8k+7:8k |
| busy | output | 1 | Transaction in progress |
| ackFail | output | 1 | A slave acknowledge slot was seen high |
| errSticky | output | 1 | Retry limit exhausted; held until next start |

## Verification
The bench pairs the master with a behavioural EEPROM model that can refuse a chosen number of write-address bytes. This exercises retry chains that either recover or run out. A master that did not restart the whole frame, or that restarted in the middle of it, would show the wrong count of START and STOP conditions or would leave the memory unwritten. An off-by-one in the retry limit would flip the final error flag.

Reads are checked across a sub-address wrap from 0xFE to 0x00. The model counts the master's acknowledge pattern, so a missing final NACK or an early NACK shows up directly. A wrong device address ends in the error state. The SCL period is also measured at a second divider setting.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TX,
    ST_RX,
    ST_STOP
  } seqState_t;

  typedef enum logic [1:0] {
    TX_DEV,
    TX_SUB,
    TX_DATA
  } txSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic   runDiv;
    logic   loadTx;
    txSel_t txSel;
    logic   rwBit;
    logic   shiftTx;
    logic   sampleRx;
    logic   storeRx;
  } dpCtrl_t;

endpackage

// File: rtl/eeprom_seq_dp.sv
module eeprom_seq_dp
  import eeprom_seq_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int DIV_W     = 16,
  parameter int IDX_W     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctl,
  input  logic [IDX_W-1:0]       byteIdx,
  input  logic [6:0]             devAddr,
  input  logic [7:0]             subAddr,
  input  logic [NUM_BYTES*8-1:0] wrData,
  input  logic [DIV_W-1:0]       clkDiv,
  input  logic                   sdaIn,
  output logic                   tick,
  output logic                   txMsb,
  output logic                   sdaBit,
  output logic [NUM_BYTES*8-1:0] rdData
);

  logic [DIV_W-1:0] divCnt;
  logic [7:0]       txSr;
  logic [7:0]       rxSr;
  logic [7:0]       dataByte;
  logic [1:0]       sdaSync;

  // quarter-period timebase
  assign tick = ctl.runDiv && (divCnt == clkDiv);

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.runDiv || tick) divCnt <= '0;
    else                              divCnt <= divCnt + 1'b1;
  end

  // two-flop synchronizer on the returned SDA level
  always_ff @(posedge clk) begin
    if (!rstN) sdaSync <= 2'b11;
    else       sdaSync <= {sdaSync[0], sdaIn};
  end
  assign sdaBit = sdaSync[1];

  // write-buffer byte select, one compare per buffer slot
  always_comb begin
    dataByte = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (byteIdx == IDX_W'(k)) dataByte = wrData[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSr <= '0;
    end else if (ctl.loadTx) begin
      case (ctl.txSel)
        TX_DEV:  txSr <= {devAddr, ctl.rwBit};
        TX_SUB:  txSr <= subAddr;
        default: txSr <= dataByte;
      endcase
    end else if (ctl.shiftTx) begin
      txSr <= {txSr[6:0], 1'b0};
    end
  end
  assign txMsb = txSr[7];

  always_ff @(posedge clk) begin
    if (!rstN)             rxSr <= '0;
    else if (ctl.sampleRx) rxSr <= {rxSr[6:0], sdaBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.storeRx) begin
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (byteIdx == IDX_W'(k)) rdData[k*8 +: 8] <= rxSr;
      end
    end
  end

endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int RETRY_W   = 4,
  parameter int IDX_W     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               readMode,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic               tick,
  input  logic               txMsb,
  input  logic               sdaBit,
  output dpCtrl_t            ctl,
  output logic [IDX_W-1:0]   byteIdx,
  output logic               sclOe,
  output logic               sdaOe,
  output logic               busy,
  output logic               ackFail,
  output logic               errSticky,
  output seqState_t          ctrlState
);

  localparam int SEQ_W = $clog2(NUM_BYTES + 2);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(NUM_BYTES + 1);
  localparam logic [IDX_W-1:0] RX_LAST  = IDX_W'(NUM_BYTES - 1);

  seqState_t          state;
  logic [1:0]         ph;
  logic [3:0]         bitCnt;
  logic [SEQ_W-1:0]   seqIdx;
  logic [IDX_W-1:0]   rxIdx;
  logic [RETRY_W-1:0] retries;
  logic               rdPhase;
  logic               rdMode;
  logic               nackSeen;
  logic               endSym;
  logic               sampleT;
  logic               ackSlot;

  assign endSym    = tick && (ph == 2'd3);
  assign sampleT   = tick && (ph == 2'd1);
  assign ackSlot   = (bitCnt == 4'd8);
  assign busy      = (state != ST_IDLE);
  assign ctrlState = state;

  // datapath strobes
  always_comb begin
    ctl          = '0;
    ctl.runDiv   = (state != ST_IDLE);
    ctl.rwBit    = rdPhase;
    ctl.shiftTx  = endSym && (state == ST_TX) && !ackSlot;
    ctl.sampleRx = sampleT && (state == ST_RX) && !ackSlot;
    byteIdx      = '0;
    if (endSym) begin
      case (state)
        ST_START: begin
          ctl.loadTx = 1'b1;
          ctl.txSel  = TX_DEV;
        end
        ST_TX: begin
          if (ackSlot && !nackSeen && !rdPhase) begin
            if (seqIdx == '0) begin
              ctl.loadTx = 1'b1;
              ctl.txSel  = TX_SUB;
            end else if (!(seqIdx == SEQ_W'(1) && rdMode) && seqIdx != SEQ_LAST) begin
              ctl.loadTx = 1'b1;
              ctl.txSel  = TX_DATA;
              byteIdx    = IDX_W'(seqIdx - 1'b1);
            end
          end
        end
        ST_RX: begin
          if (ackSlot) begin
            ctl.storeRx = 1'b1;
            byteIdx     = rxIdx;
          end
        end
        default: ;
      endcase
    end
  end

  // bus line drive: quarter 0 and 3 of a bit keep SCL low
  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    case (state)
      ST_START: begin
        sclOe = (ph == 2'd0) || (ph == 2'd3);
        sdaOe = ph[1];
      end
      ST_TX: begin
        sclOe = (ph == 2'd0) || (ph == 2'd3);
        sdaOe = !ackSlot && !txMsb;
      end
      ST_RX: begin
        sclOe = (ph == 2'd0) || (ph == 2'd3);
        sdaOe = ackSlot && (rxIdx != RX_LAST);
      end
      ST_STOP: begin
        sclOe = (ph == 2'd0);
        sdaOe = !ph[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ph        <= '0;
      bitCnt    <= '0;
      seqIdx    <= '0;
      rxIdx     <= '0;
      retries   <= '0;
      rdPhase   <= 1'b0;
      rdMode    <= 1'b0;
      nackSeen  <= 1'b0;
      ackFail   <= 1'b0;
      errSticky <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (startPulse) begin
        state     <= ST_START;
        ph        <= '0;
        bitCnt    <= '0;
        seqIdx    <= '0;
        rxIdx     <= '0;
        retries   <= '0;
        rdPhase   <= 1'b0;
        rdMode    <= readMode;
        nackSeen  <= 1'b0;
        ackFail   <= 1'b0;
        errSticky <= 1'b0;
      end
    end else if (tick) begin
      ph <= ph + 2'd1;
      if (sampleT && state == ST_TX && ackSlot && sdaBit) begin
        nackSeen <= 1'b1;
        ackFail  <= 1'b1;
      end
      if (ph == 2'd3) begin
        case (state)
          ST_START: begin
            state  <= ST_TX;
            bitCnt <= '0;
          end
          ST_TX: begin
            if (!ackSlot) begin
              bitCnt <= bitCnt + 4'd1;
            end else begin
              bitCnt <= '0;
              if (nackSeen) begin
                state <= ST_STOP;
              end else if (rdPhase) begin
                state <= ST_RX;
                rxIdx <= '0;
              end else if (seqIdx == SEQ_W'(1) && rdMode) begin
                rdPhase <= 1'b1;
                state   <= ST_START;
              end else if (seqIdx == SEQ_LAST) begin
                state <= ST_STOP;
              end else begin
                seqIdx <= seqIdx + 1'b1;
              end
            end
          end
          ST_RX: begin
            if (!ackSlot) begin
              bitCnt <= bitCnt + 4'd1;
            end else begin
              bitCnt <= '0;
              if (rxIdx == RX_LAST) state <= ST_STOP;
              else                  rxIdx <= rxIdx + 1'b1;
            end
          end
          ST_STOP: begin
            if (!nackSeen) begin
              state <= ST_IDLE;
            end else if (retries == retryLimit) begin
              errSticky <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              retries  <= retries + 1'b1;
              nackSeen <= 1'b0;
              ackFail  <= 1'b0;
              rdPhase  <= 1'b0;
              seqIdx   <= '0;
              bitCnt   <= '0;
              state    <= ST_START;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/eeprom_seq_top.sv
module eeprom_seq_top
  import eeprom_seq_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int DIV_W     = 16,
  parameter int RETRY_W   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startPulse,
  input  logic                   readMode,
  input  logic [6:0]             devAddr,
  input  logic [7:0]             subAddr,
  input  logic [NUM_BYTES*8-1:0] wrData,
  input  logic [DIV_W-1:0]       clkDiv,
  input  logic [RETRY_W-1:0]     retryLimit,
  input  logic                   sdaIn,
  output logic                   sclOe,
  output logic                   sdaOe,
  output logic [NUM_BYTES*8-1:0] rdData,
  output logic                   busy,
  output logic                   ackFail,
  output logic                   errSticky
);

  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  dpCtrl_t          ctl;
  logic [IDX_W-1:0] byteIdx;
  logic             tick;
  logic             txMsb;
  logic             sdaBit;
  seqState_t        ctrlState;

  eeprom_seq_ctrl #(
    .NUM_BYTES(NUM_BYTES),
    .RETRY_W  (RETRY_W),
    .IDX_W    (IDX_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .readMode  (readMode),
    .retryLimit(retryLimit),
    .tick      (tick),
    .txMsb     (txMsb),
    .sdaBit    (sdaBit),
    .ctl       (ctl),
    .byteIdx   (byteIdx),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe),
    .busy      (busy),
    .ackFail   (ackFail),
    .errSticky (errSticky),
    .ctrlState (ctrlState)
  );

  eeprom_seq_dp #(
    .NUM_BYTES(NUM_BYTES),
    .DIV_W    (DIV_W),
    .IDX_W    (IDX_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .byteIdx(byteIdx),
    .devAddr(devAddr),
    .subAddr(subAddr),
    .wrData (wrData),
    .clkDiv (clkDiv),
    .sdaIn  (sdaIn),
    .tick   (tick),
    .txMsb  (txMsb),
    .sdaBit (sdaBit),
    .rdData (rdData)
  );

endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk
  import eeprom_seq_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      startPulse,
  input logic      sclOe,
  input logic      sdaOe,
  input logic      busy,
  input logic      ackFail,
  input logic      errSticky,
  input seqState_t ctrlState
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe)); // R2

  AST_BUSY_ON_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy) |=> busy); // R2

  AST_SDA_FALL_ONLY_START: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && !sclOe && !$past(sclOe)) |-> (ctrlState == ST_START)); // R4

  AST_SDA_RISE_ONLY_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaOe) && !sclOe && !$past(sclOe)) |-> (ctrlState == ST_STOP)); // R4

  AST_ACKFAIL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackFail) |-> busy); // R8

  AST_GIVEUP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSticky) |-> (!busy && ackFail)); // R9

  AST_ERR_HOLDS_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |-> ackFail); // R9

  AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy) |=> (!errSticky && !ackFail)); // R10

endmodule

bind eeprom_seq_top eeprom_seq_chk uChk (.*);

// File: tb/sim_eeprom_seq_top.sv
module sim_eeprom_seq_top;

  localparam int NB  = 3;
  localparam int DW  = 16;
  localparam int RW  = 4;
  localparam logic [6:0] SLV = 7'h50;
  localparam int WD  = 150000;

  typedef struct packed {
    logic          rd;
    logic [6:0]    dev;
    logic [7:0]    sub;
    logic [NB*8-1:0] data;
    logic [3:0]    lim;
    logic [3:0]    nacks;
    logic [3:0]    attempts;
    logic          err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'h50, 8'h10, 24'hC3B2A1, 4'd3, 4'd0, 4'd1, 1'b0},
    '{1'b1, 7'h50, 8'h10, 24'h000000, 4'd3, 4'd0, 4'd1, 1'b0},
    '{1'b0, 7'h50, 8'h20, 24'h0F1E2D, 4'd3, 4'd2, 4'd3, 1'b0},
    '{1'b1, 7'h50, 8'h20, 24'h000000, 4'd1, 4'd1, 4'd2, 1'b0},
    '{1'b0, 7'h50, 8'h30, 24'h445566, 4'd1, 4'd2, 4'd2, 1'b1},
    '{1'b1, 7'h51, 8'h40, 24'h000000, 4'd0, 4'd0, 4'd1, 1'b1},
    '{1'b1, 7'h50, 8'hFE, 24'h000000, 4'd2, 4'd0, 4'd1, 1'b0},
    '{1'b0, 7'h50, 8'h05, 24'h808001, 4'd0, 4'd0, 4'd1, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            startPulse = 1'b0;
  logic            readMode = 1'b0;
  logic [6:0]      devAddr = SLV;
  logic [7:0]      subAddr = '0;
  logic [NB*8-1:0] wrData = '0;
  logic [DW-1:0]   clkDiv = 16'd2;
  logic [RW-1:0]   retryLimit = '0;
  logic            sdaIn;
  logic            sclOe, sdaOe, busy, ackFail, errSticky;
  logic [NB*8-1:0] rdData;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  eeprom_seq_top u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .readMode(readMode),
    .devAddr(devAddr), .subAddr(subAddr), .wrData(wrData), .clkDiv(clkDiv),
    .retryLimit(retryLimit), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe),
    .rdData(rdData), .busy(busy), .ackFail(ackFail), .errSticky(errSticky)
  );

  // wired-AND bus with pull-ups
  logic sclW, sdaW;
  logic slvLow = 1'b0;
  assign sclW  = ~sclOe;
  assign sdaW  = ~(sdaOe | slvLow);
  assign sdaIn = sdaW;

  // behavioural EEPROM slave
  logic [7:0] mem [256];
  logic [7:0] sr = '0;
  logic [7:0] txByte = '0;
  logic [7:0] ptr = '0;
  logic inFrame = 1'b0, slvTx = 1'b0, mstNack = 1'b0, addrOk = 1'b0, rwReq = 1'b0;
  int bitC = 0, byteC = 0;
  int nackBudget = 0;
  int startCnt = 0, stopCnt = 0, mstAckCnt = 0, mstNackCnt = 0;
  logic sawAF = 1'b0;

  always @(negedge sdaW) begin
    if (sclW === 1'b1) begin
      startCnt++;
      inFrame = 1'b1; bitC = 0; byteC = 0;
      slvTx = 1'b0; mstNack = 1'b0; slvLow = 1'b0;
    end
  end

  always @(posedge sdaW) begin
    if (sclW === 1'b1 && inFrame) begin
      stopCnt++;
      inFrame = 1'b0; slvLow = 1'b0;
    end
  end

  always @(posedge sclW) begin
    if (inFrame) begin
      if (bitC < 8) sr = {sr[6:0], sdaW};
      else if (slvTx) begin
        if (sdaW) begin mstNackCnt++; mstNack = 1'b1; end
        else mstAckCnt++;
      end
      bitC++;
    end
  end

  always @(negedge sclW) begin
    if (inFrame) begin
      if (bitC == 8) begin
        if (!slvTx) begin
          if (byteC == 0) begin
            rwReq  = sr[0];
            addrOk = (sr[7:1] == SLV) && !(sr[0] == 1'b0 && nackBudget > 0);
            if (sr[7:1] == SLV && sr[0] == 1'b0 && nackBudget > 0) nackBudget--;
            slvLow = addrOk;
          end else if (addrOk) begin
            if (byteC == 1) ptr = sr;
            else begin mem[ptr] = sr; ptr = ptr + 8'd1; end
            slvLow = 1'b1;
          end else slvLow = 1'b0;
        end else slvLow = 1'b0;
      end else if (bitC == 9) begin
        bitC = 0;
        byteC++;
        if (byteC == 1 && addrOk && rwReq) slvTx = 1'b1;
        if (slvTx && !mstNack) begin
          txByte = mem[ptr]; ptr = ptr + 8'd1; slvLow = ~txByte[7];
        end else slvLow = 1'b0;
      end else if (slvTx && !mstNack && bitC >= 1 && bitC <= 7) begin
        slvLow = ~txByte[7-bitC];
      end
    end
  end

  always @(negedge clk) if (ackFail && busy) sawAF = 1'b1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    fails++; tests++;
    $display("FAIL R2 watchdog expired: busy actual=%0b expected 0", busy);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 lines", 64'({sclOe, sdaOe}), 64'd0);
    chk("R1 flags", 64'({ackFail, errSticky}), 64'd0);
    chk("R1 rdData", 64'(rdData), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] a;
      logic [NB*8-1:0] expRd;
      readMode   = VECS[v].rd;
      devAddr    = VECS[v].dev;
      subAddr    = VECS[v].sub;
      wrData     = VECS[v].data;
      retryLimit = VECS[v].lim;
      nackBudget = int'(VECS[v].nacks);
      startCnt = 0; stopCnt = 0; mstAckCnt = 0; mstNackCnt = 0; sawAF = 1'b0;
      pulseStart();
      chk("R2 busy after start", 64'(busy), 64'd1);
      chk("R10 flags cleared at start", 64'({errSticky, ackFail}), 64'd0);
      waitIdle();
      chk("R2 lines released at end", 64'({sclW, sdaW}), 64'b11);
      chk("R9 errSticky", 64'(errSticky), 64'(VECS[v].err));
      chk("R8 ackFail at end", 64'(ackFail), 64'(VECS[v].err));
      chk("R4 stop count", 64'(stopCnt), 64'(VECS[v].attempts));
      chk("R8 start count", 64'(startCnt),
          64'(int'(VECS[v].attempts) + ((VECS[v].rd && !VECS[v].err) ? 1 : 0)));
      if (VECS[v].attempts > 1) chk("R8 ackFail seen while busy", 64'(sawAF), 64'd1);
      if (!VECS[v].rd) begin
        for (int k = 0; k < NB; k++) begin
          a = VECS[v].sub + 8'(k);
          if (VECS[v].err) chk("R9 memory untouched", 64'(mem[a]), 64'(a ^ 8'h5A));
          else chk("R5 written byte", 64'(mem[a]), 64'(VECS[v].data[k*8 +: 8]));
        end
      end else if (!VECS[v].err) begin
        for (int k = 0; k < NB; k++) begin
          a = VECS[v].sub + 8'(k);
          expRd[k*8 +: 8] = mem[a];
        end
        chk("R6 read data", 64'(rdData), 64'(expRd));
        chk("R7 master acks", 64'(mstAckCnt), 64'(NB - 1));
        chk("R7 final nack", 64'(mstNackCnt), 64'd1);
      end
    end

    // R3: SCL period at a slower divider
    begin
      time t1, t2;
      clkDiv = 16'd4;
      readMode = 1'b0; devAddr = SLV; subAddr = 8'h60; wrData = 24'h123456;
      retryLimit = '0; nackBudget = 0;
      pulseStart();
      @(posedge sclW) t1 = $time;
      @(posedge sclW) t2 = $time;
      chk("R3 SCL period cycles", 64'((t2 - t1) / 10), 64'd20);
      waitIdle();
      chk("R5 byte0 MSB-first", 64'(mem[8'h60]), 64'h56);
      chk("R5 byte2 MSB-first", 64'(mem[8'h62]), 64'h12);
    end

    // R2: start request while busy is not acted upon
    begin
      startCnt = 0;
      clkDiv = 16'd2; subAddr = 8'h70; wrData = 24'hAABBCC;
      pulseStart();
      repeat (20) @(negedge clk);
      pulseStart();
      waitIdle();
      chk("R2 single frame despite second pulse", 64'(startCnt), 64'd1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule